// File: doc/BRIEF.md
# Crypto feed interrupt controller

This block gathers the completion events of a crypto engine's four data-feed DMA channels and turns them into one interrupt line for the processor. Each channel delivers a single-cycle event pulse. The pulse is latched into a status bit. That bit stays set until software acknowledges it, and it stays set whether or not its source is enabled. Because the status bit holds, software can mask a channel, reprogram it and unmask it again, and an event that arrives in the masked window is still reported once the channel is unmasked.

Software reaches the block over a simple 32-bit register port with one-cycle strobes. The enable mask is never written directly. One write-only register sets mask bits and another clears them, so no read-modify-write is needed. The pending view is status AND enable. The usual acknowledge sequence is to read status and write the same value to the pending register, which clears exactly those status bits.

Top module: `feedirq_ctrl`

## Requirements
- R1: After a synchronous reset, the status bits, the enable mask, `irq_o` and `bus_rdata` are all zero.
- R2: An event pulse on `evt_in[i]` sets status bit i whether or not source i is enabled. The bit order is: bit 3 block-cipher receive, bit 2 block-cipher transmit, bit 1 hash receive, bit 0 public-key. Status is read at byte offset 0x00.
- R3: A write to offset 0x04 enables every source whose data bit is 1. Data bits that are 0 leave their enable bit unchanged.
- R4: A write to offset 0x08 disables every source whose data bit is 1. Data bits that are 0 leave their enable bit unchanged.
- R5: A read of offset 0x04 or offset 0x08 returns the current enable mask.
- R6: A read of offset 0x0C returns status AND enable.
- R7: Writing ones to offset 0x0C clears those status bits, whatever the enable state. Status bits written with 0 are kept.
- R8: If an event and a pending-clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is a register. It is high exactly when some bit is both set in status and enabled, and it reflects the state produced by the same clock edge. An event that arrives while its source is disabled raises `irq_o` as soon as the source is enabled.
- R10: Bits 31:4 of every read are zero. A read of any offset other than 0x00, 0x04, 0x08 or 0x0C returns zero, and so does an address whose low two bits are not zero. Writes to such addresses, and writes to offset 0x00, change nothing.
- R11: Read data is a register. It shows, in the cycle after the read strobe, the state as it was before that clock edge, and it holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| evt_in | input | NUM_SRC (4) | Per-source DMA event pulses |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every piece of internal state is visible at the ports within two cycles. A status or enable bit that is wrong shows up either on `irq_o` at the next edge or in the next read of offset 0x00, 0x04 or 0x0C. A lost event, or one that is cleared at the wrong moment, is most likely to hide in two places: the cycle where an event and an acknowledge collide, and the window where a source is masked. For that reason the directed scenarios read the registers back right after each of those situations and also watch `irq_o` at the edge where the enable changes. A read-mux fault, such as the wrong offset, nonzero upper bits or wrong read latency, appears on `bus_rdata` one cycle after the strobe.

// File: rtl/feedirq_pkg.sv
package feedirq_pkg;

  // Register selector taken from byte address bits [3:2]
  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_ENSET = 2'd1,
    SEL_ENCLR = 2'd2,
    SEL_PEND  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } reg_dec_t;

  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 2;

endpackage

// File: rtl/feedirq_src_cell.sv
module feedirq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic set_en,
  input  logic clr_en,
  input  logic ack,
  output logic stat_q,
  output logic en_q,
  output logic pend_nxt
);

  logic stat_nxt;
  logic en_nxt;

  // A new event outranks an acknowledge in the same cycle
  assign stat_nxt = (stat_q & ~ack) | evt;
  assign en_nxt   = (en_q | set_en) & ~clr_en;
  assign pend_nxt = stat_nxt & en_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      en_q   <= en_nxt;
    end
  end

endmodule

// File: rtl/feedirq_regif.sv
module feedirq_regif
  import feedirq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] stat_q,
  input  logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] set_mask,
  output logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] ack_mask,
  output logic [DATA_W-1:0]  bus_rdata
);

  localparam int HI_LSB = SEL_LSB + SEL_W;
  localparam int PAD_W  = DATA_W - NUM_SRC;

  reg_dec_t           dec;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] rd_bits;
  logic               unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:NUM_SRC];
  assign wbits        = bus_wdata[NUM_SRC-1:0];

  always_comb begin
    dec.hit = (bus_addr[ADDR_W-1:HI_LSB] == '0) && (bus_addr[SEL_LSB-1:0] == '0);
    dec.sel = reg_sel_e'(bus_addr[HI_LSB-1:SEL_LSB]);
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    ack_mask = '0;
    if (bus_wr && dec.hit) begin
      unique case (dec.sel)
        SEL_ENSET: set_mask = wbits;
        SEL_ENCLR: clr_mask = wbits;
        SEL_PEND:  ack_mask = wbits;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_bits = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_STAT:  rd_bits = stat_q;
        SEL_ENSET: rd_bits = en_q;
        SEL_ENCLR: rd_bits = en_q;
        SEL_PEND:  rd_bits = stat_q & en_q;
        default:   rd_bits = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= {{PAD_W{1'b0}}, rd_bits};
    end
  end

endmodule

// File: rtl/feedirq_irqout.sv
module feedirq_irqout #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_nxt,
  output logic               irq_o
);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |pend_nxt;
  end

endmodule

// File: rtl/feedirq_ctrl.sv
module feedirq_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend_nxt;
  logic [NUM_SRC-1:0] set_mask;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] ack_mask;

  feedirq_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_regif (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .ack_mask (ack_mask),
    .bus_rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    feedirq_src_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_in[i]),
      .set_en  (set_mask[i]),
      .clr_en  (clr_mask[i]),
      .ack     (ack_mask[i]),
      .stat_q  (stat_q[i]),
      .en_q    (en_q[i]),
      .pend_nxt(pend_nxt[i])
    );
  end

  feedirq_irqout #(
    .NUM_SRC(NUM_SRC)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .pend_nxt(pend_nxt),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/feedirq_chk.sv
module feedirq_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] evt_in,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               irq_o
);

  localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(12);

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_in) |=> ((stat_q & $past(evt_in)) == $past(evt_in)));

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_SET) |=>
      ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CLR) |=>
      ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_PEND && ((evt_in & bus_wdata[NUM_SRC-1:0]) == '0)) |=>
      ((stat_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_PEND && ((evt_in & bus_wdata[NUM_SRC-1:0]) != '0)) |=>
      ((stat_q & $past(evt_in & bus_wdata[NUM_SRC-1:0])) != '0));

  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(stat_q & en_q)));

  // R10
  rdata_upper_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM_SRC] == '0);

endmodule

bind feedirq_ctrl feedirq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_SRC(NUM_SRC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .evt_in   (evt_in),
  .stat_q   (stat_q),
  .en_q     (en_q),
  .irq_o    (irq_o)
);

// File: tb/feedirq_ctrl_test.sv
`timescale 1ns/1ps
module feedirq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_in = '0;
  logic        irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  feedirq_ctrl uut (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .evt_in   (evt_in),
    .irq_o    (irq_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] v);
    @(negedge clk); evt_in = v;
    @(negedge clk); evt_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", "irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1", "rdata after reset", bus_rdata, 32'd0);
    rd(8'h00, d); chk("R1", "status after reset", d, 32'd0);
    rd(8'h04, d); chk("R1", "enable after reset", d, 32'd0);
  endtask

  task automatic t_latch_masked;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      pulse(4'(1 << i));
      chk("R9", "irq stays low while masked", {31'd0, irq_o}, 32'd0);
    end
    rd(8'h00, d); chk("R2", "all sources latched", d, 32'h0000000F);
    rd(8'h0C, d); chk("R6", "pending with no enables", d, 32'd0);
  endtask

  task automatic t_enable_ops;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFF5);
    chk("R9", "irq after enable", {31'd0, irq_o}, 32'd1);
    rd(8'h04, d); chk("R5", "mask read at set offset", d, 32'h5);
    rd(8'h08, d); chk("R5", "mask read at clear offset", d, 32'h5);
    rd(8'h0C, d); chk("R6", "pending = status & enable", d, 32'h5);
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R3", "zero set write keeps mask", d, 32'h5);
    wr(8'h08, 32'h0);
    rd(8'h04, d); chk("R4", "zero clear write keeps mask", d, 32'h5);
    wr(8'h08, 32'h1);
    rd(8'h08, d); chk("R4", "clear one bit", d, 32'h4);
    wr(8'h04, 32'h2);
    rd(8'h04, d); chk("R3", "set adds bit", d, 32'h6);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    wr(8'h0C, 32'h3);
    rd(8'h00, d); chk("R7", "partial ack keeps others", d, 32'hC);
    rd(8'h00, d);
    wr(8'h0C, d);
    rd(8'h00, d); chk("R7", "read-back ack clears all", d, 32'h0);
    chk("R9", "irq low after ack", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    pulse(4'h6);
    @(negedge clk);
    evt_in = 4'h4; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h6;
    @(negedge clk);
    evt_in = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(8'h00, d); chk("R8", "event beats clear", d, 32'h4);
    wr(8'h0C, 32'h4);
  endtask

  task automatic t_masked_window;
    logic [31:0] d;
    wr(8'h08, 32'hF);
    pulse(4'h8);
    chk("R9", "masked event no irq", {31'd0, irq_o}, 32'd0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h8;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    chk("R9", "irq at enable edge", {31'd0, irq_o}, 32'd1);
    wr(8'h08, 32'h8);
    chk("R9", "irq drops on disable", {31'd0, irq_o}, 32'd0);
    rd(8'h00, d); chk("R2", "status kept while masked", d, 32'h8);
    wr(8'h04, 32'h8);
    @(negedge clk); evt_in = 4'h8; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h8;
    @(negedge clk); evt_in = '0; bus_wr = 1'b0; bus_wdata = '0;
    chk("R9", "irq held by racing event", {31'd0, irq_o}, 32'd1);
    wr(8'h0C, 32'h8);
    chk("R9", "irq low after final ack", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    pulse(4'h3);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R10", "status write ignored", d, 32'h3);
    wr(8'h10, 32'hF);
    wr(8'h0D, 32'hF);
    rd(8'h00, d); chk("R10", "unmapped writes ignored", d, 32'h3);
    rd(8'h04, d); chk("R10", "unmapped write left mask", d, 32'h8);
    rd(8'h10, d); chk("R10", "unmapped read zero", d, 32'h0);
    rd(8'h02, d); chk("R10", "misaligned read zero", d, 32'h0);
    wr(8'h0C, 32'hF);
  endtask

  task automatic t_read_timing;
    logic [31:0] d;
    @(negedge clk); evt_in = 4'h1; bus_rd = 1'b1; bus_addr = 8'h00;
    @(negedge clk); evt_in = '0; bus_rd = 1'b0;
    chk("R11", "read shows pre-edge state", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R11", "rdata holds without strobe", bus_rdata, 32'h0);
    rd(8'h00, d); chk("R11", "later read sees event", d, 32'h1);
    wr(8'h0C, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latch_masked();
    t_enable_ops();
    t_ack();
    t_race();
    t_masked_window();
    t_map();
    t_read_timing();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule